// File: doc/BRIEF.md
# Cross-Domain Prescaler Control for a Real-Time Counter

This block holds the control byte of a real-time counter. Software writes the byte in the bus clock domain; the block raises a busy flag and carries the byte into a separate, slower RTC clock domain. In the RTC domain the byte sets a power-of-two division ratio, gates the counting tick, and selects whether ticking continues during standby. A toggle handshake returns an acknowledge to the bus domain, and the busy flag drops once that acknowledge has been synchronised.

The output is a one-cycle tick enable in the RTC domain that a downstream counter can use. The correction-enable bit is not acted on here. It is carried across with the rest of the byte and driven out for other logic to use. A write that arrives while a crossing is still in flight is dropped, and a sticky error flag records it.

Top module: `rtc_prescale_ctrl`

## Requirements
- R1: After reset in both domains, `ctrl_rd` is 0x00, `busy` and `wr_err` are 0, and `tick`, `corr_en` and `stby_run` are 0.
- R2: Control byte fields: bit 0 enable, bit 2 correction enable, bits 6:3 prescale select N, bit 7 run in standby; bit 1 is unused. A write with `busy` low shows on `ctrl_rd` and raises `busy` from the next bus clock edge.
- R3: An accepted byte reaches the RTC side on the third RTC rising edge after the accepting bus edge: two synchroniser stages, then the load. `corr_en` and `stby_run` change at that edge.
- R4: A write while `busy` is high is ignored. `ctrl_rd` and the applied RTC-side setting keep the earlier byte, and `wr_err` is set.
- R5: `wr_err` stays set until `err_clr` is pulsed with no new ignored write in that cycle, then reads 0.
- R6: With enable set and select N, `tick` pulses once every 2^N RTC cycles. Each pulse is one RTC cycle wide, except that N = 0 gives a tick on every cycle.
- R7: With the enable bit at 0, `tick` stays low.
- R8: With run-in-standby at 0, `tick` stays low while `standby` is high. With it at 1, ticks continue at the selected ratio during standby.
- R9: When a load changes N, the prescale counter restarts at zero. The first tick comes 2^N - 1 RTC cycles after the first cycle that shows the new setting.
- R10: `corr_en` follows bit 2 of the applied byte and has no effect on `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain asynchronous reset, active low |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| err_clr | input | 1 | Clears the sticky write error flag |
| ctrl_rd | output | 8 | Last accepted control byte |
| busy | output | 1 | High while a write is crossing domains |
| wr_err | output | 1 | Sticky flag: a write was dropped while busy |
| rtc_clk | input | 1 | RTC domain clock |
| rtc_rst_n | input | 1 | RTC domain asynchronous reset, active low |
| standby | input | 1 | Standby indication, synchronous to rtc_clk |
| tick | output | 1 | One-cycle counting tick enable |
| corr_en | output | 1 | Applied correction enable bit |
| stby_run | output | 1 | Applied run-in-standby bit |

## Verification
The bench measures the distance between ticks at division ratios from 1 to 256. An off-by-one in the mask or the counter would give periods one cycle too long or too short, and a tick wider than one cycle would show up as a period of 1. It counts RTC edges from the write to the first changed output and from there to the first tick at the new ratio. A missing synchroniser stage, or a counter that is not restarted, shifts those counts. It also writes twice back to back to show that the second byte is dropped and flagged; a design that let it through would show the second byte on the readback and at the outputs. Standby with and without the run bit, and the disabled state, are checked for ticks that should not appear.

// File: rtl/rtc_prescale_ctrl.sv
`timescale 1ns/1ps
module rtc_prescale_ctrl #(
  parameter int SYNC_DEPTH = 2,
  parameter int SEL_W      = 4
) (
  input  logic       bus_clk,
  input  logic       bus_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       err_clr,
  output logic [7:0] ctrl_rd,
  output logic       busy,
  output logic       wr_err,
  input  logic       rtc_clk,
  input  logic       rtc_rst_n,
  input  logic       standby,
  output logic       tick,
  output logic       corr_en,
  output logic       stby_run
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic                  req_tgl, ack_tgl;
  logic [SYNC_DEPTH-1:0] ack_sync, req_sync;
  logic [7:0]            live;
  logic [CNT_W-1:0]      cnt, mask;
  logic                  load;

  // bus domain
  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      ctrl_rd <= '0;
      req_tgl <= 1'b0;
      wr_err  <= 1'b0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_DEPTH-2:0], ack_tgl};
      if (wr_en && !busy) begin
        ctrl_rd <= wr_data;
        req_tgl <= ~req_tgl;
      end
      if (wr_en && busy)  wr_err <= 1'b1;
      else if (err_clr)   wr_err <= 1'b0;
    end

  assign busy = req_tgl ^ ack_sync[SYNC_DEPTH-1];

  // rtc domain
  assign load = req_sync[SYNC_DEPTH-1] ^ ack_tgl;

  always_ff @(posedge rtc_clk or negedge rtc_rst_n)
    if (!rtc_rst_n) begin
      req_sync <= '0;
      ack_tgl  <= 1'b0;
      live     <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_DEPTH-2:0], req_tgl};
      if (load) begin
        live    <= ctrl_rd;
        ack_tgl <= req_sync[SYNC_DEPTH-1];
      end
    end

  always_ff @(posedge rtc_clk or negedge rtc_rst_n)
    if (!rtc_rst_n)
      cnt <= '0;
    else if (!live[0] || (load && ctrl_rd[6:3] != live[6:3]))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;

  assign mask     = (CNT_W'(1) << live[6:3]) - CNT_W'(1);
  assign tick     = live[0] && (live[7] || !standby) && (&(cnt | ~mask));
  assign corr_en  = live[2];
  assign stby_run = live[7];

  assert_busy_set_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_en && !busy |=> busy && ctrl_rd == $past(wr_data));
  assert_busy_ignore_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    busy |=> $stable(ctrl_rd));
  assert_err_set_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_en && busy |=> wr_err);
  assert_err_clear_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    err_clr && !(wr_en && busy) |=> !wr_err);
  assert_tick_width_R6: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    tick && live[6:3] != 0 && !load |=> !tick);
  assert_cnt_restart_R9: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    load && ctrl_rd[6:3] != live[6:3] |=> cnt == 0);
endmodule

// File: tb/tb_rtc_prescale_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_prescale_ctrl;
  logic bus_clk = 0, rtc_clk = 0, bus_rst_n = 0, rtc_rst_n = 0;
  logic wr_en = 0, err_clr = 0, standby = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_rd;
  logic busy, wr_err, tick, corr_en, stby_run;

  int vectors = 0, errors = 0;
  int exp_q[$];
  string cur_req = "R6";
  bit armed = 0;
  int rcyc = 0, last = 0;

  always #10 bus_clk = ~bus_clk;
  always #35 rtc_clk = ~rtc_clk;

  rtc_prescale_ctrl dut (.*);

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge rtc_clk) begin
    rcyc++;
    if (tick) begin
      if (armed && exp_q.size() > 0) chk(cur_req, rcyc - last, exp_q.pop_front());
      last = rcyc;
      armed = 1;
    end
  end

  task automatic write_byte(logic [7:0] b);
    @(negedge bus_clk); wr_en = 1; wr_data = b;
    @(negedge bus_clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge bus_clk);
    repeat (4) @(negedge rtc_clk);
  endtask

  task automatic measure(string req, int n, int reps);
    cur_req = req;
    armed = 0;
    wait (armed);
    for (int i = 0; i < reps; i++) exp_q.push_back(1 << n);
    while (exp_q.size() > 0) @(negedge rtc_clk);
  endtask

  task automatic count_ticks(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge rtc_clk);
      if (tick) n++;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; rtc_rst_n = 1;
    repeat (2) @(negedge rtc_clk);
    chk("R1 ctrl_rd", ctrl_rd, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 tick", tick, 0);
    chk("R1 corr_en", corr_en + stby_run, 0);

    // R2: accepted write readable and busy on next edge
    write_byte(8'h01);
    chk("R2 busy", busy, 1);
    chk("R2 ctrl_rd", ctrl_rd, 8'h01);
    wait_idle();
    measure("R6 N0", 0, 3);
    write_byte(8'h09); wait_idle(); measure("R6 N1", 1, 3);
    write_byte(8'h19); wait_idle(); measure("R6 N3", 3, 3);
    write_byte(8'h29); wait_idle(); measure("R6 N5", 5, 3);
    write_byte(8'h41); wait_idle(); measure("R6 N8", 8, 3);

    // R3 latency, R9 first tick, R10 correction bit
    @(negedge bus_clk); wr_en = 1; wr_data = 8'h25;
    @(posedge bus_clk); #1; wr_en = 0;
    n = 0;
    while (!corr_en && n < 10) begin @(posedge rtc_clk); n++; #1; end
    chk("R3 edges to apply", n, 3);
    chk("R10 corr_en", corr_en, 1);
    @(negedge rtc_clk);
    n = 0;
    while (!tick && n < 100) begin @(negedge rtc_clk); n++; end
    chk("R9 first tick", n, 15);
    wait_idle();
    measure("R10 N4 period", 4, 2);

    // R7 disabled
    write_byte(8'h20); wait_idle();
    count_ticks(300, n);
    chk("R7 ticks while disabled", n, 0);

    // R8 standby
    write_byte(8'h11); wait_idle();
    @(negedge rtc_clk); standby = 1;
    count_ticks(100, n);
    chk("R8 ticks in standby, run off", n, 0);
    @(negedge rtc_clk); standby = 0;
    measure("R8 N2 after standby", 2, 2);
    write_byte(8'h99); wait_idle();
    chk("R8 stby_run", stby_run, 1);
    @(negedge rtc_clk); standby = 1;
    measure("R8 N3 in standby, run on", 3, 3);
    @(negedge rtc_clk); standby = 0;

    // R4 write while busy, R5 sticky error
    write_byte(8'h81);
    write_byte(8'h04);
    chk("R4 ctrl_rd kept", ctrl_rd, 8'h81);
    chk("R4 wr_err", wr_err, 1);
    wait_idle();
    chk("R4 applied stby_run", stby_run, 1);
    chk("R4 applied corr_en", corr_en, 0);
    chk("R5 wr_err sticky", wr_err, 1);
    @(negedge bus_clk); err_clr = 1;
    @(negedge bus_clk); err_clr = 0;
    chk("R5 wr_err cleared", wr_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule